// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 data cache

This block is a 4-way set-associative L1 data cache for a CPU load/store pipe. It holds 32 KB in 32-byte lines across 256 sets. The CPU presents a word address taken from inside the page, so the set is chosen from untranslated bits. In the same cycle the translation unit supplies the physical page number, and this number is compared against the stored tags. Index and line offset together span 13 bits, which is the page offset, so every virtual alias of a physical line lands in the same set.

Hits complete combinationally in the request cycle. A miss raises `stall` until the line is resident. The CPU holds its request while stalled. A dirty victim is first written to the next level over a line-wide valid/ready port, then the missing line is fetched. After the fill the held request hits. Stores that miss allocate the line and merge the word once the fill completes. The victim is the least recently used way of the set. A translation fault cancels the access and leaves the arrays unchanged.

Top module: `vipt_dcache`

## Requirements
- R1: After reset no line is valid and LRU ages start at way0=0, way1=1, way2=2, way3=3, so way3 is the first victim. With no request, `stall`, `hit` and `mem_valid` are 0. The first access after reset misses and issues only a fill (`mem_we`=0), with no write-back.
- R2: `req_vword` is {set[7:0], word[2:0]}. The tag is the 19-bit `tlb_ppn`. The next-level line address `mem_addr` is {tag, set} (27 bits). Line word k occupies bits 32k+31:32k.
- R3: An access hits when a way in the selected set is valid and holds a tag equal to `tlb_ppn`. In that same cycle `hit`=1, `stall`=0, and `rdata` is the addressed word.
- R4: A read miss raises `stall` and requests a fill with `mem_we`=0 and `mem_addr`={ppn,set}. The cycle after `mem_ready`, the line is installed and the held request hits with the returned word.
- R5: A store that hits replaces only the addressed 32-bit word, marks the line dirty, and causes no next-level transfer.
- R6: A store that misses fetches the line, then writes the store word into it. A later read returns the stored word.
- R7: If the victim is valid and dirty, a write-back (`mem_we`=1, `mem_addr` = old {tag,set}, `mem_wdata` = the whole line) precedes the fill. A clean or invalid victim causes a fill only.
- R8: On a miss the victim is the way of that set that was accessed least recently. Each hit makes its way the most recent. Other sets are unaffected.
- R9: When `tlb_fault`=1 with a request, `hit` and `stall` are 0. No next-level transfer starts, and no tag, data, valid, dirty or LRU state changes.
- R10: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_we` and `mem_addr` hold steady. `stall` stays high for as long as the transfer waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU access request, held while stalled |
| req_we | input | 1 | 1 = store, 0 = load |
| req_vword | input | 11 | Word address within the page: {set, word} |
| req_wdata | input | 32 | Store data |
| tlb_ppn | input | 19 | Physical page number from translation |
| tlb_fault | input | 1 | Translation fault; cancels the access |
| hit | output | 1 | Access hit this cycle |
| stall | output | 1 | CPU must hold its request |
| rdata | output | 32 | Load data, valid with hit |
| mem_valid | output | 1 | Next-level transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 27 | Line address {tag, set} |
| mem_wdata | output | 256 | Write-back line |
| mem_ready | input | 1 | Next level accepts / returns the line this cycle |
| mem_rdata | input | 256 | Fill line, valid with mem_ready |

## Verification
The bench fills one set with four tags, then touches them in a chosen order. If the design got the age update wrong, it would evict a recently used line and a later access would miss where a hit is expected. Dirty lines are evicted, and the refetched data is compared against what the bench memory stored. A design that skipped the write-back, or wrote the wrong way, would return stale words. A faulting store to a resident line and a faulting read of an absent line both have to leave the arrays untouched. Reset is reapplied over a dirty line: if the valid bits were not cleared, the design would issue a spurious write-back.

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 32,
  parameter int TAG_W      = 19,
  localparam int IDX_W     = $clog2(SETS),
  localparam int WOFS_W    = $clog2(LINE_BYTES / 4),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [IDX_W+WOFS_W-1:0] req_vword,
  input  logic [31:0]             req_wdata,
  input  logic [TAG_W-1:0]        tlb_ppn,
  input  logic                    tlb_fault,
  output logic                    hit,
  output logic                    stall,
  output logic [31:0]             rdata,
  output logic                    mem_valid,
  output logic                    mem_we,
  output logic [TAG_W+IDX_W-1:0]  mem_addr,
  output logic [LINE_W-1:0]       mem_wdata,
  input  logic                    mem_ready,
  input  logic [LINE_W-1:0]       mem_rdata
);
  localparam int WAYS = 4;

  typedef enum logic [1:0] {S_IDLE, S_WBACK, S_FILL} st_t;
  st_t st;

  logic [TAG_W-1:0]     tag_q  [SETS*WAYS];
  logic [LINE_W-1:0]    data_q [SETS*WAYS];
  logic [SETS*WAYS-1:0] vld_q, drt_q;
  logic [1:0]           age_q  [SETS][WAYS];

  logic [IDX_W-1:0]  set, m_set;
  logic [WOFS_W-1:0] wsel;
  logic [TAG_W-1:0]  m_tag;
  logic [1:0]        m_way, hit_way, vic_way;
  logic [WAYS-1:0]   way_hit;
  logic              lookup;

  assign set    = req_vword[WOFS_W +: IDX_W];
  assign wsel   = req_vword[WOFS_W-1:0];
  assign lookup = (st == S_IDLE) && req_valid && !tlb_fault;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign way_hit[g] = vld_q[{set, 2'(g)}] && (tag_q[{set, 2'(g)}] == tlb_ppn);
  end

  always_comb begin
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = 2'(w);
      if (age_q[set][w] == 2'd3) vic_way = 2'(w);
    end
  end

  assign hit       = lookup && |way_hit;
  assign stall     = (st != S_IDLE) || (lookup && !hit);
  assign rdata     = data_q[{set, hit_way}][{wsel, 5'b0} +: 32];
  assign mem_valid = (st != S_IDLE);
  assign mem_we    = (st == S_WBACK);
  assign mem_addr  = mem_we ? {tag_q[{m_set, m_way}], m_set} : {m_tag, m_set};
  assign mem_wdata = data_q[{m_set, m_way}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      vld_q <= '0;
      drt_q <= '0;
      m_set <= '0;
      m_tag <= '0;
      m_way <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= 2'(w);
    end else begin
      case (st)
        S_IDLE: begin
          if (hit) begin
            if (req_we) drt_q[{set, hit_way}] <= 1'b1;
            for (int w = 0; w < WAYS; w++) begin
              if (2'(w) == hit_way) age_q[set][w] <= 2'd0;
              else if (age_q[set][w] < age_q[set][hit_way]) age_q[set][w] <= age_q[set][w] + 2'd1;
            end
          end else if (lookup) begin
            m_set <= set;
            m_tag <= tlb_ppn;
            m_way <= vic_way;
            st    <= (vld_q[{set, vic_way}] && drt_q[{set, vic_way}]) ? S_WBACK : S_FILL;
          end
        end
        S_WBACK: if (mem_ready) st <= S_FILL;
        S_FILL: begin
          if (mem_ready) begin
            vld_q[{m_set, m_way}] <= 1'b1;
            drt_q[{m_set, m_way}] <= 1'b0;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ready) begin
      tag_q[{m_set, m_way}]  <= m_tag;
      data_q[{m_set, m_way}] <= mem_rdata;
    end else if (hit && req_we) begin
      data_q[{set, hit_way}][{wsel, 5'b0} +: 32] <= req_wdata;
    end
  end

  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));
  p_fill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_we && mem_ready |=> !mem_valid);
  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && mem_ready |=> mem_valid && !mem_we);
  p_mru_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> age_q[$past(set)][$past(hit_way)] == 2'd0);
  p_fault_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && tlb_fault && !mem_valid |-> !hit && !stall);
  p_fault_no_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid && req_valid && tlb_fault |=> !mem_valid);
  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && stall);
endmodule

// File: tb/vipt_dcache_bench.sv
module vipt_dcache_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, tlb_fault = 0;
  logic [10:0] req_vword = '0;
  logic [31:0] req_wdata = '0;
  logic [18:0] tlb_ppn = '0;
  logic hit, stall, mem_valid, mem_we;
  logic [31:0] rdata;
  logic [26:0] mem_addr;
  logic [255:0] mem_wdata, mem_rdata = '0;
  logic mem_ready = 0;

  vipt_dcache u_vipt_dcache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_vword(req_vword), .req_wdata(req_wdata), .tlb_ppn(tlb_ppn),
    .tlb_fault(tlb_fault), .hit(hit), .stall(stall), .rdata(rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int mem_delay = 1, dcnt = 0, txn = 0;
  logic [26:0] last_rd, last_wr;
  logic last_op_we = 0;
  logic [255:0] last_wb;
  logic [26:0] st_addr [16];
  logic [255:0] st_data [16];
  int st_n = 0;

  function automatic logic [255:0] gen_line(input logic [26:0] a);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = {2'b10, a, 3'(k)};
    return l;
  endfunction

  function automatic logic [255:0] fetch(input logic [26:0] a);
    logic [255:0] l = gen_line(a);
    for (int i = 0; i < st_n; i++) if (st_addr[i] == a) l = st_data[i];
    return l;
  endfunction

  initial forever begin
    @(negedge clk);
    if (mem_valid && dcnt >= mem_delay) begin
      mem_ready = 1;
      dcnt = 0;
      txn++;
      last_op_we = mem_we;
      if (mem_we) begin
        last_wr = mem_addr;
        last_wb = mem_wdata;
        st_addr[st_n % 16] = mem_addr;
        st_data[st_n % 16] = mem_wdata;
        if (st_n < 16) st_n++;
      end else begin
        last_rd = mem_addr;
        mem_rdata = fetch(mem_addr);
      end
    end else begin
      mem_ready = 0;
      if (mem_valid) dcnt++;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] s, input logic [2:0] w,
                        input logic [18:0] p, input logic [31:0] d,
                        output logic first_hit, output logic [31:0] rd, output int ncyc);
    @(negedge clk);
    req_valid = 1; req_we = we; req_vword = {s, w}; tlb_ppn = p; req_wdata = d;
    #1;
    first_hit = hit;
    ncyc = 0;
    while (stall) begin
      @(negedge clk); #1; ncyc++;
    end
    rd = rdata;
    @(negedge clk);
    req_valid = 0; req_we = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  localparam logic [18:0] TA = 19'h00011, TB = 19'h00022, TC = 19'h00033,
                          TD = 19'h00044, TE = 19'h00055;

  typedef struct packed {
    logic        we;
    logic [7:0]  s;
    logic [2:0]  w;
    logic [18:0] p;
    logic [31:0] d;
    logic        h;
    logic [31:0] x;
    logic [2:0]  n;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{1'b0, 8'd5, 3'd2, TA, 32'h0,        1'b0, 32'h0,        3'd1},
    '{1'b0, 8'd5, 3'd7, TA, 32'h0,        1'b1, 32'h0,        3'd0},
    '{1'b1, 8'd5, 3'd3, TA, 32'hDEAD0003, 1'b1, 32'h0,        3'd0},
    '{1'b0, 8'd5, 3'd3, TA, 32'h0,        1'b1, 32'hDEAD0003, 3'd0},
    '{1'b0, 8'd9, 3'd0, TA, 32'h0,        1'b0, 32'h0,        3'd1},
    '{1'b1, 8'd5, 3'd1, TB, 32'hBEEF0001, 1'b0, 32'h0,        3'd1},
    '{1'b0, 8'd5, 3'd1, TB, 32'h0,        1'b1, 32'hBEEF0001, 3'd0},
    '{1'b0, 8'd5, 3'd0, TB, 32'h0,        1'b1, 32'h0,        3'd0},
    '{1'b0, 8'd5, 3'd4, TC, 32'h0,        1'b0, 32'h0,        3'd1},
    '{1'b0, 8'd5, 3'd4, TD, 32'h0,        1'b0, 32'h0,        3'd1},
    '{1'b0, 8'd5, 3'd0, TE, 32'h0,        1'b0, 32'h0,        3'd2},
    '{1'b0, 8'd5, 3'd3, TA, 32'h0,        1'b0, 32'hDEAD0003, 3'd2},
    '{1'b0, 8'd5, 3'd0, TC, 32'h0,        1'b1, 32'h0,        3'd0},
    '{1'b0, 8'd5, 3'd1, TB, 32'h0,        1'b0, 32'hBEEF0001, 3'd1},
    '{1'b0, 8'd5, 3'd5, TD, 32'h0,        1'b0, 32'h0,        3'd1}
  };

  bit done = 0;

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic fh; logic [31:0] rd, exp; int nc, t0;
    string tg;
    do_reset;
    @(negedge clk); #1;
    check(!stall && !hit && !mem_valid, "R1 idle after reset", {stall, hit, mem_valid}, 0);

    for (int i = 0; i < 15; i++) begin
      t0 = txn;
      access(VEC[i].we, VEC[i].s, VEC[i].w, VEC[i].p, VEC[i].d, fh, rd, nc);
      tg = (i >= 10) ? "R8 lru" : VEC[i].h ? "R3 hit" : VEC[i].we ? "R6 write-allocate" : "R4 read miss";
      check(fh == VEC[i].h, tg, fh, VEC[i].h);
      if (!VEC[i].we) begin
        exp = (VEC[i].x != 0) ? VEC[i].x : {2'b10, VEC[i].p, VEC[i].s, VEC[i].w};
        check(rd == exp, (VEC[i].x != 0) ? "R5 stored word" : "R2 word select", rd, exp);
      end
      check(txn - t0 == int'(VEC[i].n), (i == 2) ? "R5 write hit no traffic" : "R7 transfer count",
            txn - t0, VEC[i].n);
      if (i == 0) begin
        check(last_rd == {TA, 8'd5}, "R2 fill address", last_rd, {TA, 8'd5});
        check(last_op_we == 0, "R1 first transfer is fill", last_op_we, 0);
      end
      if (i == 10) begin
        check(last_wr == {TA, 8'd5}, "R7 write-back address", last_wr, {TA, 8'd5});
        check(last_wb[127:96] == 32'hDEAD0003, "R7 write-back data", last_wb[127:96], 32'hDEAD0003);
        check(last_op_we == 0 && last_rd == {TE, 8'd5}, "R7 fill after write-back", last_rd, {TE, 8'd5});
      end
    end

    t0 = txn;
    @(negedge clk);
    req_valid = 1; req_we = 1; req_vword = {8'd5, 3'd0}; tlb_ppn = TC; req_wdata = 32'h0BAD0BAD; tlb_fault = 1;
    #1;
    check(!hit && !stall, "R9 faulting store cancelled", {hit, stall}, 0);
    @(negedge clk);
    req_vword = {8'd5, 3'd2}; tlb_ppn = 19'h00777; req_we = 0;
    #1;
    check(!hit && !stall, "R9 faulting miss cancelled", {hit, stall}, 0);
    @(negedge clk);
    req_valid = 0; tlb_fault = 0;
    repeat (2) @(negedge clk);
    check(txn == t0 && !mem_valid, "R9 no transfer on fault", txn - t0, 0);
    access(0, 8'd5, 3'd0, TC, 0, fh, rd, nc);
    check(fh && rd == {2'b10, TC, 8'd5, 3'd0}, "R9 resident word unchanged", rd, {2'b10, TC, 8'd5, 3'd0});
    access(0, 8'd5, 3'd2, 19'h00777, 0, fh, rd, nc);
    check(!fh, "R9 faulted miss not installed", fh, 0);

    mem_delay = 4;
    access(0, 8'd12, 3'd6, 19'h01234, 0, fh, rd, nc);
    check(nc >= 5, "R10 stall spans slow fill", nc, 5);
    check(rd == {2'b10, 19'h01234, 8'd12, 3'd6}, "R10 data after slow fill", rd, {2'b10, 19'h01234, 8'd12, 3'd6});
    mem_delay = 1;

    access(1, 8'd12, 3'd6, 19'h01234, 32'h5A5A5A5A, fh, rd, nc);
    check(fh, "R5 store hit", fh, 1);
    do_reset;
    t0 = txn;
    access(0, 8'd12, 3'd6, 19'h01234, 0, fh, rd, nc);
    check(!fh, "R1 miss after reset", fh, 0);
    check(txn - t0 == 1 && last_op_we == 0, "R1 no write-back after reset", txn - t0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule